// File: doc/BRIEF.md
# Half-Duplex Buffered SPI Master

This block is a register-programmed SPI master for serial flash and similar devices. Software fills a 32-bit command word and a 32-byte data buffer, programs how many bits each phase moves, and writes a start bit. The block then runs up to three phases back to back. The first phase shifts command bits out. The second phase shifts buffer bits out. The third phase samples bits from MISO into the same buffer. Software polls a busy flag and reads the received bytes back through the register port.

The serial clock runs in mode 0 and is derived from the system clock by a divider of N+2. Chip selects are plain register bits. Because they are independent of transfers, a chip select can stay asserted across several transactions, which lets software build one long flash command out of several shorter ones.

Top module: `hdspi_master`

## Requirements
- R1: After reset, busy reads 0, `sckO` and `mosiO` are 0, every `csNO` bit is 1, and the registers at 0x00, 0x04, 0x08, 0x28, 0x2C and 0x38 read 0.
- R2: Written values read back at these byte offsets: the command word at 0x04, eight buffer words at 0x08 to 0x24, configuration at 0x28 (divider N in [27:16], mode bits [5:3]), and phase counts at 0x2C (command bits in [29:24], outgoing bits in [8:0], incoming bits in [20:12], stored as written).
- R3: A write to 0x00 with bit 8 set while idle starts a transfer. Busy (bit 16 of 0x00) is 1 from the next clock for exactly (total bits)×(N+2) cycles, or for one cycle when all three counts are 0.
- R4: The serial clock works in mode 0. SCK and MOSI are low while idle. Each bit holds SCK low for (N+2)−floor((N+2)/2) cycles and then high for floor((N+2)/2) cycles. MOSI changes only while SCK is low.
- R5: The phases run in the order command, data out, data in. A phase whose count is 0 is skipped and emits no SCK pulses.
- R6: Command bits leave the command word most significant byte first: byte 3 (bits 31:24), then byte 2, and so on.
- R7: Outgoing buffer bits leave in ascending byte order. Byte 0 is bits 7:0 of the word at 0x08 and byte 4 is bits 7:0 of the word at 0x0C.
- R8: MISO is sampled on each rising SCK edge of the data-in phase. Received bytes fill the buffer from byte 0 upward in the same little-endian layout. Bytes beyond the received count keep their previous contents.
- R9: With configuration bit 3 clear, each byte moves bit 7 first. With it set, each byte moves bit 0 first. The order applies to all three phases.
- R10: `csNO[n]` is the inverse of bit n of the register at 0x38. It holds its value through and between transfers.
- R11: A start written while busy is ignored: no extra bits are sent and busy does not extend.
- R12: While busy, writes to 0x04, the buffer and 0x2C have no effect. Buffer reads return the stored contents.
- R13: A command count above 32 acts as 32. A data count above 256 acts as 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 6 | Register byte offset for reads and writes |
| regWrEn | input | 1 | Register write strobe, one cycle per write |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational from regAddr |
| sckO | output | 1 | Serial clock, mode 0 |
| mosiO | output | 1 | Serial data to the device |
| misoI | input | 1 | Serial data from the device |
| csNO | output | 2 | Chip selects, active low |

## Verification
A wrong bit or phase counter shows up first on MOSI, as a bit from the wrong byte or wrong position within the first SCK period after the fault. It also shows up as a wrong count of SCK rising edges, and as a busy window whose length differs from bits×(N+2). A fault in the sampling strobe or the capture index appears only when the buffer is read back after busy falls. The bench therefore compares every received word against bytes it drove itself. Divider faults change the number of high cycles per bit, and the bench counts those directly during every transfer.

// File: rtl/hdspi_pkg.sv
package hdspi_pkg;
  localparam int ADDR_W       = 6;
  localparam int BUF_WORDS    = 8;
  localparam int BUF_BITS     = BUF_WORDS * 32;
  localparam int IDX_W        = $clog2(BUF_BITS);
  localparam int LEN_W        = IDX_W + 1;
  localparam int WSEL_W       = $clog2(BUF_WORDS);
  localparam int CMD_MAX_BITS = 32;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_OPC  = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_BUF0 = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_CFG  = 6'h28;
  localparam logic [ADDR_W-1:0] OFS_CNT  = 6'h2C;
  localparam logic [ADDR_W-1:0] OFS_CSEL = 6'h38;

  typedef enum logic [2:0] {
    PH_IDLE, PH_CMD, PH_DOUT, PH_DIN, PH_FIN
  } phase_e;

  typedef struct packed {
    phase_e           phase;
    logic [IDX_W-1:0] bitIdx;
    logic             sampleEn;
    logic             busy;
  } xferStrobe_t;
endpackage

// File: rtl/hdspi_seq.sv
module hdspi_seq
  import hdspi_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [DIV_W-1:0]  divN,
  input  logic [5:0]        cmdField,
  input  logic [8:0]        outField,
  input  logic [8:0]        inField,
  output xferStrobe_t       ctl,
  output logic              sckO
);
  localparam int CYC_W = DIV_W + 1;

  phase_e            phaseQ;
  logic [IDX_W-1:0]  bitIdxQ;
  logic [CYC_W-1:0]  cycQ;
  logic [CYC_W-1:0]  periodQ;
  logic [LEN_W-1:0]  cmdLenQ, outLenQ, inLenQ;
  logic [LEN_W-1:0]  cmdLenC, outLenC, inLenC;
  logic [LEN_W-1:0]  curLen;
  logic [CYC_W-1:0]  lowLen;
  logic              bitPhase;
  logic              lastCyc;
  logic              lastBit;

  // saturate the phase counts at their maximum
  always_comb begin
    cmdLenC = (cmdField > 6'(CMD_MAX_BITS)) ? LEN_W'(CMD_MAX_BITS) : LEN_W'(cmdField);
    outLenC = (outField > 9'(BUF_BITS)) ? LEN_W'(BUF_BITS) : LEN_W'(outField);
    inLenC  = (inField  > 9'(BUF_BITS)) ? LEN_W'(BUF_BITS) : LEN_W'(inField);
  end

  function automatic phase_e pickNext(phase_e cur, logic [LEN_W-1:0] c,
                                      logic [LEN_W-1:0] o, logic [LEN_W-1:0] i);
    phase_e n;
    case (cur)
      PH_IDLE: n = (c != '0) ? PH_CMD : (o != '0) ? PH_DOUT : (i != '0) ? PH_DIN : PH_FIN;
      PH_CMD:  n = (o != '0) ? PH_DOUT : (i != '0) ? PH_DIN : PH_IDLE;
      PH_DOUT: n = (i != '0) ? PH_DIN : PH_IDLE;
      default: n = PH_IDLE;
    endcase
    return n;
  endfunction

  always_comb begin
    case (phaseQ)
      PH_CMD:  curLen = cmdLenQ;
      PH_DOUT: curLen = outLenQ;
      PH_DIN:  curLen = inLenQ;
      default: curLen = LEN_W'(1);
    endcase
  end

  assign lowLen   = periodQ - (periodQ >> 1);
  assign bitPhase = (phaseQ == PH_CMD) || (phaseQ == PH_DOUT) || (phaseQ == PH_DIN);
  assign lastCyc  = (cycQ == periodQ - CYC_W'(1));
  assign lastBit  = (LEN_W'(bitIdxQ) == curLen - LEN_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ  <= PH_IDLE;
      bitIdxQ <= '0;
      cycQ    <= '0;
      periodQ <= CYC_W'(2);
      cmdLenQ <= '0;
      outLenQ <= '0;
      inLenQ  <= '0;
    end else begin
      case (phaseQ)
        PH_IDLE: begin
          if (startReq) begin
            cmdLenQ <= cmdLenC;
            outLenQ <= outLenC;
            inLenQ  <= inLenC;
            periodQ <= CYC_W'(divN) + CYC_W'(2);
            bitIdxQ <= '0;
            cycQ    <= '0;
            phaseQ  <= pickNext(PH_IDLE, cmdLenC, outLenC, inLenC);
          end
        end
        PH_FIN: phaseQ <= PH_IDLE;
        default: begin
          if (lastCyc) begin
            cycQ <= '0;
            if (lastBit) begin
              bitIdxQ <= '0;
              phaseQ  <= pickNext(phaseQ, cmdLenQ, outLenQ, inLenQ);
            end else begin
              bitIdxQ <= bitIdxQ + IDX_W'(1);
            end
          end else begin
            cycQ <= cycQ + CYC_W'(1);
          end
        end
      endcase
    end
  end

  assign sckO         = bitPhase && (cycQ >= lowLen);
  assign ctl.phase    = phaseQ;
  assign ctl.bitIdx   = bitIdxQ;
  assign ctl.sampleEn = (phaseQ == PH_DIN) && (cycQ == lowLen - CYC_W'(1));
  assign ctl.busy     = (phaseQ != PH_IDLE);
endmodule

// File: rtl/hdspi_regs_dp.sv
module hdspi_regs_dp
  import hdspi_pkg::*;
#(
  parameter int DIV_W  = 12,
  parameter int CS_NUM = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              misoI,
  output logic              mosiO,
  output logic [CS_NUM-1:0] csNO,
  input  xferStrobe_t       ctl,
  output logic              startReq,
  output logic [DIV_W-1:0]  divN,
  output logic [5:0]        cmdField,
  output logic [8:0]        outField,
  output logic [8:0]        inField
);
  localparam int FLAT_W = IDX_W;

  logic [31:0]         opcodeQ;
  logic [31:0]         bufQ [BUF_WORDS];
  logic [DIV_W-1:0]    divQ;
  logic [2:0]          modeQ;
  logic [5:0]          cntCmdQ;
  logic [8:0]          cntOutQ, cntInQ;
  logic [CS_NUM-1:0]   cselQ;
  logic [BUF_BITS-1:0] bufFlat;
  logic                dataWrOk;
  logic [2:0]          bitPos;
  logic [FLAT_W-1:0]   flatIdx;
  logic [4:0]          opcIdx;
  logic [WSEL_W-1:0]   rxWord;
  logic [4:0]          rxBit;

  genvar gw;
  generate
    for (gw = 0; gw < BUF_WORDS; gw++) begin : g_flat
      assign bufFlat[gw*32 +: 32] = bufQ[gw];
    end
  endgenerate

  assign dataWrOk = regWrEn && !ctl.busy;
  assign startReq = regWrEn && (regAddr == OFS_CTRL) && regWrData[8];

  // bit position within the current byte; modeQ[0] selects LSB-first
  assign bitPos  = modeQ[0] ? ctl.bitIdx[2:0] : ~ctl.bitIdx[2:0];
  assign flatIdx = {ctl.bitIdx[IDX_W-1:3], bitPos};
  assign opcIdx  = {~ctl.bitIdx[4:3], bitPos};
  assign rxWord  = flatIdx[FLAT_W-1:5];
  assign rxBit   = flatIdx[4:0];

  always_comb begin
    case (ctl.phase)
      PH_CMD:  mosiO = opcodeQ[opcIdx];
      PH_DOUT: mosiO = bufFlat[flatIdx];
      default: mosiO = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opcodeQ <= '0;
      divQ    <= '0;
      modeQ   <= '0;
      cntCmdQ <= '0;
      cntOutQ <= '0;
      cntInQ  <= '0;
      cselQ   <= '0;
      for (int w = 0; w < BUF_WORDS; w++) bufQ[w] <= '0;
    end else begin
      if (regWrEn && regAddr == OFS_CFG) begin
        divQ  <= regWrData[16 +: DIV_W];
        modeQ <= regWrData[5:3];
      end
      if (regWrEn && regAddr == OFS_CSEL) cselQ <= regWrData[CS_NUM-1:0];
      if (dataWrOk && regAddr == OFS_OPC) opcodeQ <= regWrData;
      if (dataWrOk && regAddr == OFS_CNT) begin
        cntCmdQ <= regWrData[29:24];
        cntInQ  <= regWrData[20:12];
        cntOutQ <= regWrData[8:0];
      end
      for (int w = 0; w < BUF_WORDS; w++) begin
        if (dataWrOk && regAddr == OFS_BUF0 + ADDR_W'(4 * w))
          bufQ[w] <= regWrData;
        else if (ctl.sampleEn && rxWord == WSEL_W'(w))
          bufQ[w][rxBit] <= misoI;
      end
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      OFS_CTRL: regRdData[16] = ctl.busy;
      OFS_OPC:  regRdData = opcodeQ;
      OFS_CFG: begin
        regRdData[16 +: DIV_W] = divQ;
        regRdData[5:3]         = modeQ;
      end
      OFS_CNT:  regRdData = {2'b0, cntCmdQ, 3'b0, cntInQ, 3'b0, cntOutQ};
      OFS_CSEL: regRdData[CS_NUM-1:0] = cselQ;
      default: begin
        for (int w = 0; w < BUF_WORDS; w++)
          if (regAddr == OFS_BUF0 + ADDR_W'(4 * w)) regRdData = bufQ[w];
      end
    endcase
  end

  assign csNO     = ~cselQ;
  assign divN     = divQ;
  assign cmdField = cntCmdQ;
  assign outField = cntOutQ;
  assign inField  = cntInQ;
endmodule

// File: rtl/hdspi_master.sv
module hdspi_master
  import hdspi_pkg::*;
#(
  parameter int DIV_W  = 12,
  parameter int CS_NUM = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [5:0]        regAddr,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              sckO,
  output logic              mosiO,
  input  logic              misoI,
  output logic [CS_NUM-1:0] csNO
);
  xferStrobe_t      ctlS;
  logic             startReq;
  logic [DIV_W-1:0] divN;
  logic [5:0]       cmdField;
  logic [8:0]       outField, inField;
  logic             busyW;

  assign busyW = ctlS.busy;

  hdspi_seq #(.DIV_W(DIV_W)) seq_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .divN(divN),
    .cmdField(cmdField), .outField(outField), .inField(inField),
    .ctl(ctlS), .sckO(sckO)
  );

  hdspi_regs_dp #(.DIV_W(DIV_W), .CS_NUM(CS_NUM)) dp_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .misoI(misoI),
    .mosiO(mosiO), .csNO(csNO), .ctl(ctlS), .startReq(startReq),
    .divN(divN), .cmdField(cmdField), .outField(outField), .inField(inField)
  );
endmodule

// File: rtl/hdspi_checks.sv
module hdspi_checks
  import hdspi_pkg::*;
#(
  parameter int CS_NUM = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              sckO,
  input logic              mosiO,
  input logic              busy,
  input logic              regWrEn,
  input logic [5:0]        regAddr,
  input logic              wrStartBit,
  input logic [CS_NUM-1:0] wrCsel,
  input logic [CS_NUM-1:0] csNO
);
  assert_sck_idle_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sckO);

  assert_mosi_idle_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mosiO);

  assert_mosi_hold_high_R4: assert property (@(posedge clk) disable iff (!rstN)
    (sckO && $past(sckO)) |-> $stable(mosiO));

  assert_busy_needs_start_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(regWrEn && regAddr == OFS_CTRL && wrStartBit));

  assert_csel_pins_R10: assert property (@(posedge clk) disable iff (!rstN)
    $past(regWrEn && regAddr == OFS_CSEL) |-> (csNO == ~$past(wrCsel)));
endmodule

bind hdspi_master hdspi_checks #(.CS_NUM(CS_NUM)) chk_i (
  .clk(clk), .rstN(rstN), .sckO(sckO), .mosiO(mosiO), .busy(busyW),
  .regWrEn(regWrEn), .regAddr(regAddr), .wrStartBit(regWrData[8]),
  .wrCsel(regWrData[CS_NUM-1:0]), .csNO(csNO)
);

// File: tb/hdspi_master_tb_top.sv
`timescale 1ns/1ps
module hdspi_master_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        sckO, mosiO;
  logic        misoI = 1'b0;
  logic [1:0]  csNO;

  int nChecks = 0;
  int nFails  = 0;

  logic [31:0] opM;
  logic [31:0] bufM [0:7];
  logic [7:0]  rxPat [0:31];
  int          riseCnt = 0;
  int          rxBase = 0;
  bit          rxLsb = 0;
  logic        mosiCap [0:599];
  int          busyCyc, sckHi;

  always #2 clk = ~clk;

  hdspi_master dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .sckO(sckO),
    .mosiO(mosiO), .misoI(misoI), .csNO(csNO)
  );

  function automatic logic misoFor(int r);
    int k;
    if (r < rxBase || r - rxBase >= 256) return 1'b0;
    k = r - rxBase;
    return rxLsb ? rxPat[k/8][k%8] : rxPat[k/8][7 - k%8];
  endfunction

  // device model: capture MOSI at each rising SCK, present the next MISO bit
  always @(posedge sckO) begin
    if (riseCnt < 600) mosiCap[riseCnt] = mosiO;
    riseCnt = riseCnt + 1;
    misoI = misoFor(riseCnt);
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = '0; regWrData = '0;
  endtask

  task automatic regRd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
    regAddr = '0;
  endtask

  function automatic logic expBit(int i, int cmdE, bit lsb);
    int by, bp, k;
    if (i < cmdE) begin
      by = i / 8;
      bp = lsb ? i % 8 : 7 - i % 8;
      return opM[(3 - by) * 8 + bp];
    end
    k  = i - cmdE;
    by = k / 8;
    bp = lsb ? k % 8 : 7 - k % 8;
    return bufM[by / 4][(by % 4) * 8 + bp];
  endfunction

  task automatic waitIdle();
    #1;
    busyCyc = 0; sckHi = 0;
    while (regRdData[16] === 1'b1 && busyCyc < 20000) begin
      busyCyc++;
      if (sckO) sckHi++;
      @(negedge clk);
      #1;
    end
  endtask

  // program, start, wait; check busy length, SCK shape, edges and MOSI stream
  task automatic runXfer(string tag, int cmd, int outb, int inb, int div, bit lsb);
    int cmdE, outE, inE, per, mism;
    cmdE = (cmd > 32) ? 32 : cmd;
    outE = (outb > 256) ? 256 : outb;
    inE  = (inb > 256) ? 256 : inb;
    per  = div + 2;
    regWr(6'h28, (div << 16) | (int'(lsb) << 3));
    regWr(6'h2C, ((cmd & 63) << 24) | ((inb & 511) << 12) | (outb & 511));
    riseCnt = 0; rxBase = cmdE + outE; rxLsb = lsb;
    misoI = misoFor(0);
    @(negedge clk);
    regAddr = 6'h00; regWrData = 32'h100; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
    waitIdle();
    chk({tag, " R3 busy cycles"}, busyCyc,
        (cmdE + outE + inE == 0) ? 1 : (cmdE + outE + inE) * per);
    chk({tag, " R4 sck high cycles"}, sckHi, (cmdE + outE + inE) * (per / 2));
    chk({tag, " R5 sck rises"}, riseCnt, cmdE + outE + inE);
    mism = 0;
    for (int i = 0; i < cmdE + outE; i++)
      if (mosiCap[i] !== expBit(i, cmdE, lsb)) mism++;
    chk({tag, " R6 R7 mosi stream mismatches"}, mism, 0);
    for (int j = 0; j < inE / 8; j++) bufM[j/4][(j%4)*8 +: 8] = rxPat[j];
  endtask

  task automatic checkBuf(string tag);
    logic [31:0] d;
    for (int w = 0; w < 8; w++) begin
      regRd(6'(8 + 4*w), d);
      chk({tag, " R8 buffer word"}, d, bufM[w]);
    end
  endtask

  task automatic testReset();
    logic [31:0] d;
    chk("R1 sck idle", 32'(sckO), 0);
    chk("R1 mosi idle", 32'(mosiO), 0);
    chk("R1 cs idle", 32'(csNO), 32'h3);
    regRd(6'h00, d); chk("R1 ctrl", d, 0);
    regRd(6'h04, d); chk("R1 opcode", d, 0);
    regRd(6'h08, d); chk("R1 buf0", d, 0);
    regRd(6'h28, d); chk("R1 cfg", d, 0);
    regRd(6'h2C, d); chk("R1 cnt", d, 0);
    regRd(6'h38, d); chk("R1 csel", d, 0);
  endtask

  task automatic testRegs();
    logic [31:0] d;
    opM = 32'hA1B2C3D4;
    regWr(6'h04, opM);
    for (int w = 0; w < 8; w++) begin
      bufM[w] = 32'h11223344 + w * 32'h01010101;
      regWr(6'(8 + 4*w), bufM[w]);
    end
    regRd(6'h04, d); chk("R2 opcode readback", d, opM);
    checkBuf("R2");
    regWr(6'h28, 32'h0ABC0038);
    regRd(6'h28, d); chk("R2 cfg readback", d, 32'h0ABC0038);
    regWr(6'h2C, 32'h2A0FF1FF);
    regRd(6'h2C, d); chk("R2 cnt readback", d, 32'h2A0FF1FF);
    regWr(6'h38, 32'h1); #1 chk("R10 cs0 asserted", 32'(csNO), 32'h2);
    regWr(6'h38, 32'h3); #1 chk("R10 both asserted", 32'(csNO), 32'h0);
    regRd(6'h38, d); chk("R2 csel readback", d, 32'h3);
    regWr(6'h38, 32'h0); #1 chk("R10 released", 32'(csNO), 32'h3);
  endtask

  task automatic testCommand();
    opM = 32'h9F0A0B0C;
    regWr(6'h04, opM);
    runXfer("cmd8 N0", 8, 0, 0, 0, 0);
    runXfer("cmd32 N3", 32, 0, 0, 3, 0);
  endtask

  task automatic testAllPhases();
    regWr(6'h38, 32'h1);
    for (int j = 0; j < 32; j++) rxPat[j] = 8'h5A ^ 8'(j * 37);
    runXfer("full N1", 16, 24, 16, 1, 0);
    checkBuf("full");
    chk("R10 cs held after transfer", 32'(csNO), 32'h2);
    runXfer("skipcmd N0", 0, 8, 0, 0, 0);
    regWr(6'h38, 32'h0);
  endtask

  task automatic testLsb();
    for (int j = 0; j < 32; j++) rxPat[j] = 8'hC3 + 8'(j * 11);
    runXfer("lsb R9 N2", 8, 8, 8, 2, 1);
    checkBuf("lsb R9");
  endtask

  task automatic testZero();
    runXfer("zero", 0, 0, 0, 0, 0);
  endtask

  task automatic testBusyBlock();
    logic [31:0] d;
    regWr(6'h28, 10 << 16);
    regWr(6'h2C, 32 << 24);
    riseCnt = 0; rxBase = 32;
    @(negedge clk);
    regAddr = 6'h00; regWrData = 32'h100; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    regWr(6'h04, 32'hDEADBEEF);
    regWr(6'h08, 32'hCAFEF00D);
    regWr(6'h2C, 32'h3F1FF1FF);
    regWr(6'h00, 32'h100);
    regRd(6'h08, d); chk("R12 buffer read while busy", d, bufM[0]);
    regAddr = 6'h00;
    waitIdle();
    repeat (40) @(negedge clk);
    #1 chk("R11 still idle after ignored start", 32'(regRdData[16]), 0);
    chk("R11 sck rises", riseCnt, 32);
    regRd(6'h04, d); chk("R12 opcode unchanged", d, opM);
    regRd(6'h08, d); chk("R12 buffer unchanged", d, bufM[0]);
    regRd(6'h2C, d); chk("R12 cnt unchanged", d, 32'h20000000);
  endtask

  task automatic testSaturate();
    for (int j = 0; j < 32; j++) rxPat[j] = 8'(j * 29 + 7);
    runXfer("sat R13", 63, 0, 300, 0, 0);
    checkBuf("sat R13");
  endtask

  initial begin
    #(200000 * 4);
    nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRegs();
    testCommand();
    testAllPhases();
    testLsb();
    testZero();
    testBusyBlock();
    testSaturate();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule